// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block sequences an external dual-slope integrating converter through its four control phases. It drives a two-bit phase code to the converter and watches the converter's zero-crossing comparator. Auto-zero and integrate each run for a programmable number of system ticks, where one tick is a fixed fraction of the input clock. The de-integrate phase counts ticks until the comparator falls, and that count becomes the conversion result. Integrator-zero then waits for the comparator to rise again before a new cycle starts.

A result register holds the de-integrate count, a polarity bit and an overrange flag from the last completed conversion. An active-low enable input stops the sequence and parks the converter in auto-zero. An active-low data-valid output is low whenever the phase is auto-zero. The comparator and enable inputs are asynchronous, so each passes through a synchronizer.

States: HALT (forced auto-zero), AZ, INT, DINT and IZ. Transitions are HALT→AZ, AZ→INT, INT→DINT, DINT→IZ (by comparator fall or by overrange) and IZ→AZ. Any state moves to HALT while the enable is inactive.

Top module: `dslope_seq`

## Requirements
- R1: The phase code is 2'b01 in HALT and AZ, 2'b10 in INT, 2'b11 in DINT and 2'b00 in IZ. The phases follow the order AZ, INT, DINT, IZ and back to AZ.
- R2: One tick occurs every DIV (4) clocks. AZ and INT each last (2^LOAD_W − load) × 2^LOW_W ticks, so each lasts 4 × that many clocks. With the defaults, a load of 0xFF gives 256 ticks and a load of 0x00 gives 65536 ticks.
- R3: The load value is captured on entry to AZ (continuously while in HALT). Both AZ and the following INT use that captured value, even if `load_val` changes after entry.
- R4: DINT starts on the tick that ends INT. A falling comparator edge ends it 3 clocks after `cmp_in` falls (two synchronizer stages plus the edge register). On that same edge, `res_count` takes the number of ticks elapsed in DINT and `res_ovr` takes count bit CW.
- R5: `res_pol` holds the synchronized comparator level sampled on the clock edge that ends INT.
- R6: If DINT reaches twice the integrate tick count without a comparator fall, DINT ends and IZ is entered. `res_count` then reads all ones and `res_ovr` reads 1.
- R7: IZ holds while the synchronized comparator is low. It moves to AZ on the first tick that sees the comparator high.
- R8: When `conv_en_n` goes high, the phase code reads 2'b01 exactly 3 clocks later, from any phase, and it stays 2'b01 while the enable is high. An aborted conversion leaves the result register unchanged. After release, AZ starts on a tick and runs a full count.
- R9: `dv_n` is low in exactly the cycles where the phase code is 2'b01.
- R10: After reset the block is in HALT (phase 2'b01, `dv_n` low) with the result register at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; the tick is derived from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | 1 | Converter zero-crossing comparator, asynchronous |
| conv_en_n | input | 1 | Active-low conversion enable, asynchronous |
| load_val | input | LOAD_W | Upper part of the AZ/INT period preset |
| phase_code | output | 2 | Phase code to the converter |
| dv_n | output | 1 | Active-low strobe, low during auto-zero |
| res_count | output | LOAD_W+LOW_W | Last de-integrate tick count |
| res_pol | output | 1 | Polarity of the last conversion |
| res_ovr | output | 1 | Overrange flag, also bit CW of the count |

## Verification
Every phase that starts on a tick is measured in clocks by sampling the phase code on falling edges. AZ and INT must span exactly 4 × ticks samples, and an overrange DINT must span exactly 8 × the integrate ticks. A comparator fall driven M clocks after the first DINT sample must leave the phase code at 2'b11 two samples later and show 2'b00 on the third. At that point the count must equal floor((M+2)/4). A raised enable is checked the same way: the old code two samples later and 2'b01 on the third. A sweep over eight load values alternates the polarity and the fall position.

// File: rtl/dss_pkg.sv
package dss_pkg;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_AZ,
        ST_INT,
        ST_DINT,
        ST_IZ
    } dss_state_e;

    localparam logic [1:0] PH_AZ   = 2'b01;
    localparam logic [1:0] PH_INT  = 2'b10;
    localparam logic [1:0] PH_DINT = 2'b11;
    localparam logic [1:0] PH_IZ   = 2'b00;

endpackage

// File: rtl/dss_sync.sv
module dss_sync #(
    parameter int W                  = 2,
    parameter int STAGES             = 2,
    parameter logic [W-1:0] RST_VAL  = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/dss_tick.sv
module dss_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [DW-1:0] div_q;

    assign tick = (div_q == DW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DW'(1);
        end
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/dss_fsm.sv
module dss_fsm
    import dss_pkg::*;
#(
    parameter int LOAD_W = 8,
    parameter int LOW_W  = 8,
    localparam int CW    = LOAD_W + LOW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmp_s,
    input  logic              en_s,
    input  logic [LOAD_W-1:0] load_val,
    output logic [1:0]        phase_code,
    output logic              dv_n,
    output logic [CW-1:0]     res_count,
    output logic              res_pol,
    output logic              res_ovr
);

    localparam int DW = CW + 1;

    dss_state_e        state, nxt;
    logic [CW-1:0]     cnt;
    logic [DW-1:0]     dcnt;
    logic [LOAD_W-1:0] load_q;
    logic              pol_q;
    logic              cmp_d;

    logic              fall;
    logic              cnt_max;
    logic [CW-1:0]     preset_cur;
    logic [CW-1:0]     preset_q;
    logic [DW-1:0]     n_ticks;
    logic [DW:0]       lim2;
    logic [DW-1:0]     lim_m1;

    assign fall       = cmp_d & ~cmp_s;
    assign cnt_max    = &cnt;
    assign preset_cur = {load_val, {LOW_W{1'b0}}};
    assign preset_q   = {load_q, {LOW_W{1'b0}}};
    assign n_ticks    = (DW'(1) << CW) - DW'(preset_q);
    assign lim2       = {n_ticks, 1'b0};
    assign lim_m1     = DW'(lim2 - (DW+1)'(1));

    // next-state selection
    always_comb begin
        nxt = state;
        if (en_s) begin
            nxt = ST_HALT;
        end else begin
            unique case (state)
                ST_HALT: if (tick)                          nxt = ST_AZ;
                ST_AZ:   if (tick && cnt_max)               nxt = ST_INT;
                ST_INT:  if (tick && cnt_max)               nxt = ST_DINT;
                ST_DINT: if (fall || (tick && dcnt == lim_m1)) nxt = ST_IZ;
                ST_IZ:   if (tick && cmp_s)                 nxt = ST_AZ;
                default:                                    nxt = ST_HALT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= nxt;
    end

    // period counters and result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            dcnt      <= '0;
            load_q    <= '0;
            pol_q     <= 1'b0;
            cmp_d     <= 1'b1;
            res_count <= '0;
            res_pol   <= 1'b0;
            res_ovr   <= 1'b0;
        end else begin
            cmp_d <= cmp_s;
            if (en_s || state == ST_HALT) begin
                load_q <= load_val;
                cnt    <= preset_cur;
            end else begin
                unique case (state)
                    ST_AZ: begin
                        if (tick) begin
                            if (cnt_max) cnt <= preset_q;
                            else         cnt <= cnt + CW'(1);
                        end
                    end
                    ST_INT: begin
                        if (tick) begin
                            if (cnt_max) begin
                                dcnt  <= '0;
                                pol_q <= cmp_s;
                            end else begin
                                cnt <= cnt + CW'(1);
                            end
                        end
                    end
                    ST_DINT: begin
                        if (fall) begin
                            res_count <= dcnt[CW-1:0];
                            res_ovr   <= dcnt[CW];
                            res_pol   <= pol_q;
                        end else if (tick) begin
                            if (dcnt == lim_m1) begin
                                res_count <= '1;
                                res_ovr   <= 1'b1;
                                res_pol   <= pol_q;
                            end else begin
                                dcnt <= dcnt + DW'(1);
                            end
                        end
                    end
                    ST_IZ: begin
                        if (tick && cmp_s) begin
                            cnt    <= preset_cur;
                            load_q <= load_val;
                        end
                    end
                    ST_HALT: ;
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_HALT, ST_AZ: phase_code = PH_AZ;
            ST_INT:         phase_code = PH_INT;
            ST_DINT:        phase_code = PH_DINT;
            ST_IZ:          phase_code = PH_IZ;
            default:        phase_code = PH_AZ;
        endcase
        dv_n = !(state == ST_HALT || state == ST_AZ);
    end

    // R1
    az_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AZ && !en_s) |=> state inside {ST_AZ, ST_INT});

    // R1
    dint_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DINT && !en_s) |=> state inside {ST_DINT, ST_IZ});

    // R2
    int_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_INT && state == ST_DINT) |-> $past(tick));

    // R8
    halt_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_s |=> state == ST_HALT);

    // R6
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DINT |-> dcnt <= lim_m1);

    // R4
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_DINT |=> ($stable(res_count) && $stable(res_ovr) && $stable(res_pol)));

endmodule

// File: rtl/dslope_seq.sv
module dslope_seq #(
    parameter int LOAD_W      = 8,
    parameter int LOW_W       = 8,
    parameter int DIV         = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmp_in,
    input  logic                    conv_en_n,
    input  logic [LOAD_W-1:0]       load_val,
    output logic [1:0]              phase_code,
    output logic                    dv_n,
    output logic [LOAD_W+LOW_W-1:0] res_count,
    output logic                    res_pol,
    output logic                    res_ovr
);

    logic [1:0] sync_q;
    logic       tick;

    dss_sync #(
        .W       (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b11)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cmp_in, conv_en_n}),
        .q     (sync_q)
    );

    dss_tick #(
        .DIV (DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    dss_fsm #(
        .LOAD_W (LOAD_W),
        .LOW_W  (LOW_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cmp_s      (sync_q[1]),
        .en_s       (sync_q[0]),
        .load_val   (load_val),
        .phase_code (phase_code),
        .dv_n       (dv_n),
        .res_count  (res_count),
        .res_pol    (res_pol),
        .res_ovr    (res_ovr)
    );

    // R9
    dv_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_code == 2'b01) == !dv_n);

endmodule

// File: tb/dslope_seq_bench.sv
module dslope_seq_bench;

    localparam int LOAD_W = 8;
    localparam int LOW_W  = 2;
    localparam int CW     = LOAD_W + LOW_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cmp_in;
    logic              conv_en_n;
    logic [LOAD_W-1:0] load_val;
    logic [1:0]        phase_code;
    logic              dv_n;
    logic [CW-1:0]     res_count;
    logic              res_pol;
    logic              res_ovr;

    int checks  = 0;
    int errors  = 0;
    int dv_bad  = 0;

    always #10 clk = ~clk;

    dslope_seq #(
        .LOAD_W      (LOAD_W),
        .LOW_W       (LOW_W),
        .DIV         (4),
        .SYNC_STAGES (2)
    ) u_dslope_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_in     (cmp_in),
        .conv_en_n  (conv_en_n),
        .load_val   (load_val),
        .phase_code (phase_code),
        .dv_n       (dv_n),
        .res_count  (res_count),
        .res_pol    (res_pol),
        .res_ovr    (res_ovr)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_phase(input logic [1:0] code, input int lim, input string req);
        int k = 0;
        while (phase_code != code && k < lim) begin
            @(negedge clk);
            k++;
        end
        chk(phase_code == code, req, phase_code, code);
    endtask

    task automatic run_len(input logic [1:0] code, output int n);
        n = 0;
        while (phase_code == code && n < 100000) begin
            n++;
            if (dv_n != (code != 2'b01)) dv_bad++;
            @(negedge clk);
        end
    endtask

    task automatic conv(input int ld, input int m, input bit polhi, input bit do_az);
        int n;
        int t4 = 16 * (256 - ld);
        if (do_az) begin
            int iz_bad = 0;
            load_val = 8'(ld);
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (phase_code != 2'b00) iz_bad++;
            end
            chk(iz_bad == 0, "R7 IZ hold", iz_bad, 0);
            cmp_in = 1'b1;
            wait_phase(2'b01, 20, "R7 IZ exit");
            cmp_in   = polhi;
            load_val = 8'(ld ^ 5);
            run_len(2'b01, n);
            chk(n == t4, "R2 R3 AZ length", n, t4);
        end
        run_len(2'b10, n);
        chk(n == t4, "R2 R3 INT length", n, t4);
        chk(phase_code == 2'b11, "R1 DINT after INT", phase_code, 3);
        if (!polhi) cmp_in = 1'b1;
        repeat (m) @(negedge clk);
        cmp_in = 1'b0;
        repeat (2) @(negedge clk);
        chk(phase_code == 2'b11, "R4 fall latency early", phase_code, 3);
        @(negedge clk);
        chk(phase_code == 2'b00, "R4 fall latency", phase_code, 0);
        chk(res_count == CW'((m + 2) / 4), "R4 count", res_count, (m + 2) / 4);
        chk(res_pol == polhi, "R5 polarity", res_pol, polhi);
        chk(res_ovr == 1'b0, "R4 ovr clear", res_ovr, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [CW-1:0] keep_cnt;
        logic          keep_pol;
        logic          keep_ovr;

        rst_n     = 1'b0;
        cmp_in    = 1'b1;
        conv_en_n = 1'b1;
        load_val  = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(phase_code == 2'b01, "R10 reset phase", phase_code, 1);
        chk(dv_n == 1'b0, "R10 reset dv_n", dv_n, 0);
        chk(res_count == '0 && !res_pol && !res_ovr, "R10 reset result", res_count, 0);

        // sweep of load values, polarity and fall position
        conv_en_n = 1'b0;
        wait_phase(2'b10, 300, "R1 first INT");
        for (int i = 0; i < 8; i++) begin
            conv(255 - i, 3 + 7 * i, (i % 2) == 0, i != 0);
        end

        // abort by enable during INT
        cmp_in = 1'b1;
        wait_phase(2'b01, 20, "R7 IZ exit");
        wait_phase(2'b10, 600, "R1 INT");
        keep_cnt = res_count;
        keep_pol = res_pol;
        keep_ovr = res_ovr;
        conv_en_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(phase_code == 2'b10, "R8 force latency early", phase_code, 2);
        @(negedge clk);
        chk(phase_code == 2'b01 && dv_n == 1'b0, "R8 forced AZ", phase_code, 1);
        repeat (20) @(negedge clk);
        chk(phase_code == 2'b01, "R8 halt held", phase_code, 1);
        chk(res_count == keep_cnt && res_pol == keep_pol && res_ovr == keep_ovr,
            "R8 result kept", res_count, keep_cnt);

        // overrange with smallest period
        load_val  = 8'hFF;
        conv_en_n = 1'b0;
        wait_phase(2'b10, 300, "R8 restart");
        run_len(2'b10, n);
        chk(n == 16, "R2 INT after restart", n, 16);
        run_len(2'b11, n);
        chk(n == 32, "R6 DINT length", n, 32);
        chk(res_count == '1, "R6 count saturated", res_count, (1 << CW) - 1);
        chk(res_ovr == 1'b1, "R6 ovr flag", res_ovr, 1);
        chk(res_pol == 1'b1, "R5 polarity high", res_pol, 1);
        run_len(2'b00, n);
        chk(n == 4, "R7 IZ with comparator high", n, 4);
        chk(phase_code == 2'b01, "R1 AZ after IZ", phase_code, 1);

        chk(dv_bad == 0, "R9 dv_n tracking", dv_bad, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule